// File: doc/BRIEF.md
# Four-Channel Compare-Match Pulse Timer

This block holds four independent 16-bit timing channels behind one small register bus, each with its own waveform output pin and interrupt line. Every channel counts ticks taken from a divided copy of the system clock, compares the count against four general compare registers, and can clear its counter on a chosen match. That clear sets the length of the waveform period.

In pulse-width mode a channel's pin begins each period at a programmed starting level. The match on compare register A applies a programmed action to the pin. The match that clears the counter puts the starting level back. Register A therefore sets the duty and the clearing register sets the period. Software starts and halts all channels through one shared run register. While a channel is halted it can set its pin to a fixed level by writing the pin-control register. The duty register can be rewritten while a channel runs, so the duty changes without a restart.

Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `tpwm_top`

## Requirements
- R1: After reset every register reads 0, all channels are halted, and all pins and interrupt lines are low.
- R2: The run register is at address 0x00, with bit n running channel n. While a channel's bit is 0, its counter and pin hold their values unless the bus writes them.
- R3: Channel n's registers are at address 0x10 + 0x40*n plus these offsets: control 0x00, mode 0x04, pin control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, and compare A, B, C and D at 0x18, 0x1C, 0x20 and 0x24. Each written register reads back the value written, without aliasing into another channel.
- R4: Control bits [1:0] hold a divide code k. With the rising edge selected (control bits [4:3] = 0), the counter advances once every 4^k clock cycles. The first advance falls on clock edge 4^k after the edge that writes the run bit.
- R5: With control bits [4:3] = 1 (falling edge), the first advance falls on edge 4^k/2 and repeats every 4^k cycles. With bits [4:3] = 2 (both edges) and k ≥ 1, the counter advances every 4^k/2 cycles.
- R6: Control bits [7:5] choose the clearing match: 0 none (the counter wraps), 1 A, 2 B, 5 C, 6 D. A tick that finds the counter equal to the chosen register loads 0, so a value P gives a period of P+1 ticks.
- R7: In mode 2 (mode bits [2:0]), the pin holds the starting level (pin-control bit 2) from the clearing tick until the A match. The A match applies the action in pin-control bits [1:0]: 0 keep, 1 low, 2 high, 3 toggle. The next clearing match puts the starting level back.
- R8: A write to pin control while the channel is halted drives the pin to the new bit-2 level on that clock edge.
- R9: Rewriting compare A while the channel runs changes the duty from the following periods on, and leaves the run bit and the counter running.
- R10: Every match on A, B, C or D sets status bit 0, 1, 2 or 3. Writing 1 to a status bit clears it. If a clearing write and a match on the same bit land on the same edge, the bit ends up set.
- R11: A channel's interrupt line is high exactly when some status bit is set and its enable bit (same position) is set.
- R12: In mode 2 with A equal to the clearing register, putting the starting level back wins over the A action, and the pin stays at the starting level.
- R13: In mode 0 the A match applies its pin action, but the clearing match does not put the starting level back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | Waveform pin of each channel |
| irq | output | 4 | Interrupt line of each channel |

## Verification
Two events can land on the same edge. One is a bus write that clears a status bit; the other is a compare match that sets that same bit. The bench counts edges from the start write so that a write-one-to-clear to the A status bit lands on the tick where the counter equals A. It then halts the channel before the next match and expects the bit to read back as 1. A second collision, the A match against the period clear when both compare values are equal, is judged by counting pin samples over whole periods. Every sample must be at the starting level.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
    parameter int unsigned CNT_W  = 16;         // counter and register width
    parameter int unsigned NCMP   = 4;          // compare registers per channel
    parameter int unsigned DIV_W  = 2;          // width of the divide code
    parameter int unsigned PSC_W  = 2 * ((1 << DIV_W) - 1); // divider counter width

    localparam logic [5:0] OFF_CTRL = 6'h00;
    localparam logic [5:0] OFF_MODE = 6'h04;
    localparam logic [5:0] OFF_PINC = 6'h08;
    localparam logic [5:0] OFF_IEN  = 6'h0C;
    localparam logic [5:0] OFF_STS  = 6'h10;
    localparam logic [5:0] OFF_CNT  = 6'h14;
    localparam logic [5:0] OFF_CMP0 = 6'h18;

    localparam logic [2:0] MODE_PULSE = 3'd2;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    typedef struct packed {
        logic [7:0]                  ctrl;
        logic [6:0]                  mode;
        logic [2:0]                  pinc;
        logic [NCMP-1:0]             ien;
        logic [NCMP-1:0]             sts;
        logic [CNT_W-1:0]            cnt;
        logic [NCMP-1:0][CNT_W-1:0]  cmp;
        logic [PSC_W-1:0]            psc;
        logic                        pin;
    } chan_st_t;
endpackage

// File: rtl/tpwm_tick.sv
module tpwm_tick
    import tpwm_pkg::*;
(
    input  logic [PSC_W-1:0] psc,
    input  logic [DIV_W-1:0] div_code,
    input  logic [1:0]       edge_sel,
    output logic             tick
);
    logic [PSC_W-1:0] mask;
    logic             rise;
    logic             fall;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PSC_W; i++) begin
            if (i < 2 * int'(div_code)) mask[i] = 1'b1;
        end
        rise = (psc & mask) == mask;
        fall = (psc & mask) == (mask >> 1);
        case (edge_sel)
            2'd0:    tick = rise;
            2'd1:    tick = fall;
            default: tick = rise | fall;
        endcase
    end
endmodule

// File: rtl/tpwm_chan.sv
module tpwm_chan
    import tpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr,
    input  logic [5:0]        off,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pin,
    output logic              irq,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NCMP-1:0]   sts_o
);
    chan_st_t        q, d;
    logic            tick;
    logic [NCMP-1:0] hit;
    logic            clr;

    tpwm_tick u_tick (
        .psc      (q.psc),
        .div_code (q.ctrl[DIV_W-1:0]),
        .edge_sel (q.ctrl[4:3]),
        .tick     (tick)
    );

    always_comb begin
        d     = q;
        hit   = '0;
        d.psc = run ? q.psc + 1'b1 : '0;
        for (int i = 0; i < NCMP; i++) begin
            hit[i] = run && tick && (q.cnt == q.cmp[i]);
        end
        case (q.ctrl[7:5])
            3'd1:    clr = hit[0];
            3'd2:    clr = hit[1];
            3'd5:    clr = hit[2];
            3'd6:    clr = hit[3];
            default: clr = 1'b0;
        endcase
        if (run && tick) d.cnt = clr ? '0 : q.cnt + 1'b1;
        // period restore outranks the duty action
        if (q.mode[2:0] == MODE_PULSE && clr) begin
            d.pin = q.pinc[2];
        end else if (hit[0]) begin
            case (pin_act_e'(q.pinc[1:0]))
                ACT_LOW:    d.pin = 1'b0;
                ACT_HIGH:   d.pin = 1'b1;
                ACT_TOGGLE: d.pin = ~q.pin;
                default:    d.pin = q.pin;
            endcase
        end
        if (wr) begin
            case (off)
                OFF_CTRL: d.ctrl = wdata[7:0];
                OFF_MODE: d.mode = wdata[6:0];
                OFF_PINC: begin
                    d.pinc = wdata[2:0];
                    if (!run) d.pin = wdata[2];
                end
                OFF_IEN:  d.ien = wdata[NCMP-1:0];
                OFF_STS:  d.sts = q.sts & ~wdata[NCMP-1:0];
                OFF_CNT:  d.cnt = wdata;
                default:  ;
            endcase
            for (int i = 0; i < NCMP; i++) begin
                if (off == OFF_CMP0 + 6'(4 * i)) d.cmp[i] = wdata;
            end
        end
        d.sts = d.sts | hit;    // a match beats a same-edge clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (off)
            OFF_CTRL: rdata = CNT_W'(q.ctrl);
            OFF_MODE: rdata = CNT_W'(q.mode);
            OFF_PINC: rdata = CNT_W'(q.pinc);
            OFF_IEN:  rdata = CNT_W'(q.ien);
            OFF_STS:  rdata = CNT_W'(q.sts);
            OFF_CNT:  rdata = q.cnt;
            default:  ;
        endcase
        for (int i = 0; i < NCMP; i++) begin
            if (off == OFF_CMP0 + 6'(4 * i)) rdata = q.cmp[i];
        end
    end

    assign pin   = q.pin;
    assign irq   = |(q.sts & q.ien);
    assign cnt_o = q.cnt;
    assign sts_o = q.sts;
endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
    import tpwm_pkg::*;
#(
    parameter int unsigned NCH    = 4,   // channels; windows must fit the address space
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    irq
);
    localparam logic [ADDR_W-1:0] RUN_ADDR  = '0;
    localparam logic [ADDR_W-1:0] WIN_BASE  = ADDR_W'(8'h10);
    localparam int unsigned       WIN_SHIFT = 6;
    localparam int unsigned       IDX_W     = ADDR_W - WIN_SHIFT;

    logic [NCH-1:0]              run_d, run_q;
    logic [ADDR_W-1:0]           rel;
    logic                        in_win;
    logic [NCH-1:0]              sel;
    logic [CNT_W-1:0]            ch_rdata [NCH];
    logic [NCH-1:0][CNT_W-1:0]   ch_cnt;
    logic [NCH-1:0][NCMP-1:0]    ch_sts;

    assign rel    = bus_addr - WIN_BASE;
    assign in_win = bus_addr >= WIN_BASE;

    always_comb begin
        run_d = run_q;
        if (bus_wr && bus_addr == RUN_ADDR) run_d = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign sel[n] = in_win && (rel[ADDR_W-1:WIN_SHIFT] == IDX_W'(n));
        tpwm_chan u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run_q[n]),
            .wr    (bus_wr && sel[n]),
            .off   (rel[WIN_SHIFT-1:0]),
            .wdata (bus_wdata),
            .rdata (ch_rdata[n]),
            .pin   (pwm_out[n]),
            .irq   (irq[n]),
            .cnt_o (ch_cnt[n]),
            .sts_o (ch_sts[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == RUN_ADDR) bus_rdata = CNT_W'(run_q);
        for (int n = 0; n < NCH; n++) begin
            if (sel[n]) bus_rdata = ch_rdata[n];
        end
    end
endmodule

// File: rtl/tpwm_chk.sv
module tpwm_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 16,
    parameter int unsigned NC  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [NCH-1:0]          run,
    input logic [NCH-1:0]          pin,
    input logic [NCH-1:0]          irq,
    input logic [NCH-1:0][CW-1:0]  cnt,
    input logic [NCH-1:0][NC-1:0]  sts
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R2: a halted channel keeps its count when the bus is idle
        p_halt_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !bus_wr) |=> $stable(cnt[g]));

        // R8: a halted channel's pin only moves on a bus write
        p_halt_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !bus_wr) |=> $stable(pin[g]));

        // R6: the count only steps by one or returns to zero
        p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(bus_wr) && cnt[g] != $past(cnt[g]))
            |-> (cnt[g] == CW'($past(cnt[g]) + 1'b1) || cnt[g] == '0));

        // R10: a status bit is only cleared by a bus write
        p_sts_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((~sts[g] & $past(sts[g])) != '0) |-> $past(bus_wr));

        // R11: no pending status, no interrupt
        p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[g] == '0) |-> !irq[g]);
    end
endmodule

bind tpwm_top tpwm_chk #(
    .NCH (NCH),
    .CW  (tpwm_pkg::CNT_W),
    .NC  (tpwm_pkg::NCMP)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_wr (bus_wr),
    .run    (run_q),
    .pin    (pwm_out),
    .irq    (irq),
    .cnt    (ch_cnt),
    .sts    (ch_sts)
);

// File: tb/sim_tpwm_top.sv
module sim_tpwm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pwm_out;
    logic [3:0]  irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz with 1 ns units

    tpwm_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .irq       (irq)
    );

    function automatic logic [7:0] ca(int ch, int off);
        return 8'(8'h10 + ch * 8'h40 + off);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_for(logic [15:0] mask, int cyc);
        wr(8'h00, mask);
        idle(cyc - 1);
        wr(8'h00, 16'h0);
    endtask

    task automatic count_high(int ch, int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            h += int'(pwm_out[ch]);
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(8'h00, v);        check("R1 run reg", v, 0);
        rd(ca(0, 0), v);     check("R1 ctrl", v, 0);
        rd(ca(3, 8'h14), v); check("R1 counter", v, 0);
        rd(ca(1, 8'h10), v); check("R1 status", v, 0);
        check("R1 pins", pwm_out, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_map;
        logic [15:0] v;
        for (int n = 0; n < 4; n++) wr(ca(n, 8'h18), 16'h1000 + 16'(n));
        for (int n = 0; n < 4; n++) begin
            rd(ca(n, 8'h18), v);
            check("R3 compare A per channel", v, 32'h1000 + n);
        end
        wr(ca(2, 8'h24), 16'hBEEF);
        rd(ca(2, 8'h24), v); check("R3 compare D", v, 16'hBEEF);
        rd(ca(1, 8'h24), v); check("R3 no alias", v, 0);
    endtask

    task automatic t_park;
        wr(ca(1, 8'h08), 16'h4);
        check("R8 park high", pwm_out[1], 1);
        wr(ca(1, 8'h08), 16'h0);
        check("R8 park low", pwm_out[1], 0);
    endtask

    task automatic t_run_halt;
        logic [15:0] v;
        run_for(16'h1, 10);
        rd(ca(0, 8'h14), v); check("R2 count after run", v, 10);
        idle(5);
        rd(ca(0, 8'h14), v); check("R2 count held", v, 10);
    endtask

    task automatic t_div;
        logic [15:0] v;
        wr(ca(0, 8'h14), 0); wr(ca(0, 0), 16'h02);
        run_for(16'h1, 48);
        rd(ca(0, 8'h14), v); check("R4 div16 rising", v, 3);
        wr(ca(0, 8'h14), 0); wr(ca(0, 0), 16'h0A);
        run_for(16'h1, 40);
        rd(ca(0, 8'h14), v); check("R5 div16 falling", v, 3);
        wr(ca(0, 8'h14), 0); wr(ca(0, 0), 16'h12);
        run_for(16'h1, 40);
        rd(ca(0, 8'h14), v); check("R5 div16 both", v, 5);
    endtask

    task automatic t_clear;
        logic [15:0] v;
        wr(ca(0, 0), 16'h40); wr(ca(0, 8'h1C), 4); wr(ca(0, 8'h14), 0);
        run_for(16'h1, 7);
        rd(ca(0, 8'h14), v); check("R6 clear on B", v, 2);
        wr(ca(0, 0), 16'hA0); wr(ca(0, 8'h20), 2); wr(ca(0, 8'h14), 0);
        run_for(16'h1, 7);
        rd(ca(0, 8'h14), v); check("R6 clear on C", v, 1);
    endtask

    task automatic t_pulse;
        int h;
        logic [15:0] v;
        wr(ca(0, 0), 16'h40); wr(ca(0, 8'h04), 2);
        wr(ca(0, 8'h18), 3); wr(ca(0, 8'h1C), 9); wr(ca(0, 8'h14), 0);
        wr(ca(0, 8'h08), 16'h5);
        wr(8'h00, 16'h1);
        count_high(0, 30, h);
        check("R7 high samples over 3 periods", h, 12);
        wr(ca(0, 8'h18), 6);
        idle(10);
        count_high(0, 20, h);
        check("R9 new duty over 2 periods", h, 14);
        rd(8'h00, v); check("R9 still running", v, 1);
        wr(8'h00, 16'h0);
    endtask

    task automatic t_equal;
        int h;
        logic [15:0] v;
        wr(ca(0, 8'h14), 0); wr(ca(0, 8'h18), 9); wr(ca(0, 8'h1C), 9);
        wr(ca(0, 8'h10), 16'hF); wr(ca(0, 8'h08), 16'h5);
        wr(8'h00, 16'h1);
        count_high(0, 30, h);
        wr(8'h00, 16'h0);
        check("R12 pin held at start level", h, 30);
        rd(ca(0, 8'h10), v); check("R10 A and B flags set", v & 16'h3, 3);
    endtask

    task automatic t_status;
        logic [15:0] v;
        wr(ca(0, 8'h20), 16'hFFFF); wr(ca(0, 8'h24), 16'hFFFF);
        wr(ca(0, 8'h18), 2); wr(ca(0, 8'h1C), 4); wr(ca(0, 8'h14), 0);
        wr(ca(0, 8'h10), 16'hF);
        wr(8'h00, 16'h1);
        idle(2);
        wr(ca(0, 8'h10), 16'h1);    // lands on the A match edge
        wr(8'h00, 16'h0);
        rd(ca(0, 8'h10), v); check("R10 set wins over clear", v, 1);
        wr(ca(0, 8'h10), 16'h1);
        rd(ca(0, 8'h10), v); check("R10 write-one clears", v, 0);
        run_for(16'h1, 6);
        wr(ca(0, 8'h0C), 16'h0); check("R11 masked", irq[0], 0);
        wr(ca(0, 8'h0C), 16'h4); check("R11 other enable", irq[0], 0);
        wr(ca(0, 8'h0C), 16'h1); check("R11 enabled", irq[0], 1);
        wr(ca(0, 8'h10), 16'h3); check("R11 cleared", irq[0], 0);
    endtask

    task automatic t_normal;
        int h;
        wr(ca(2, 8'h18), 4); wr(ca(2, 0), 16'h20); wr(ca(2, 8'h14), 0);
        wr(ca(2, 8'h08), 16'h3);
        wr(8'h00, 16'h4);
        count_high(2, 40, h);
        wr(8'h00, 16'h0);
        check("R13 toggle without restore", h, 20);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_map;
        t_park;
        t_run_halt;
        t_div;
        t_clear;
        t_pulse;
        t_equal;
        t_status;
        t_normal;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule